// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an internal request bus with a valid/ready handshake and an external asynchronous static RAM of 524,288 bytes (19-bit word address, 8-bit data). It accepts one single-word read or write at a time. It registers the address and the write data, and it drives the memory's two chip selects, its output enable and its read/write line. It holds each phase for a number of clock cycles worked out from the clock period and from the memory's minimum timing intervals. A read returns its byte with a one-cycle response pulse. A write ends with a one-cycle completion pulse.

All timing limits are module parameters given in nanoseconds. Each limit becomes a cycle count equal to the ceiling of the interval over the clock period, with a floor of one cycle. The same RTL can therefore serve faster or slower memory grades and both supply ranges. The memory data bus is split into an outgoing byte, an incoming byte and a registered driver-enable, so a pad ring can build the tri-state buffer. Between accesses the memory is deselected and sits in standby.

Top module: `asyncSramCtl`

## Requirements
- R1: After reset, reqReady is 1, memCeLowN is 1, memCeHigh is 0, memOeN is 1, memRwN is 1, memDqDriveEn is 0, and rspValid and wrDone are 0.
- R2: Whenever reqReady is 1, the memory is in standby: memCeLowN is 1, memCeHigh is 0, memOeN is 1 and memDqDriveEn is 0.
- R3: A request is taken only in a cycle where reqValid and reqReady are both 1. reqReady is 0 from the cycle after acceptance until the access and its recovery are over. A reqValid raised while reqReady is 0 and withdrawn before reqReady returns causes no memory access and changes no stored data.
- R4: A read holds memCeLowN=0, memCeHigh=1, memOeN=0 and memRwN=1 with a stable memAddr for exactly RD cycles. RD is the largest of the cycle counts for the address-access, output-enable-access and read-cycle times (7 at the defaults: 55 ns, 30 ns and 55 ns with an 8 ns clock).
- R5: The byte on memDqIn at the clock edge that ends the read phase appears on rspRdata, which then holds it. rspValid is 1 for exactly one cycle, RD+1 cycles after the accepting edge.
- R6: A write holds memCeLowN=0, memCeHigh=1, memRwN=0 and memOeN=1 for exactly WR cycles. WR is the largest of the cycle counts for write pulse, enable-to-end-of-write, data setup and write cycle (7 at the defaults). During those cycles memDqDriveEn is 1 and memDqOut carries the request data.
- R7: memDqDriveEn is never 1 while memRwN is 1, so it falls no later than the edge where memRwN returns high, and it is never 1 while memOeN is 0.
- R8: After a read phase ends, the memory stays deselected for TURN cycles (4 at the default 25 ns release time) before reqReady returns. At least TURN cycles therefore pass before the data bus can be driven.
- R9: wrDone is a one-cycle pulse, WR+1 cycles after the accepting edge of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | One-cycle read data valid pulse |
| rspRdata | output | 8 | Last read byte |
| wrDone | output | 1 | One-cycle write completion pulse |
| memAddr | output | 19 | Memory address |
| memCeLowN | output | 1 | Active-low chip select |
| memCeHigh | output | 1 | Active-high chip select |
| memOeN | output | 1 | Active-low output enable |
| memRwN | output | 1 | Read (1) / write (0) |
| memDqOut | output | 8 | Byte driven toward the memory |
| memDqIn | input | 8 | Byte returned from the memory |
| memDqDriveEn | output | 1 | Enables the pad driver for memDqOut |

## Verification
The hardest case to reach from the ports is a write accepted right after a read. Only there can the bus turnaround be breached, so the bench issues read-then-write pairs to the same address and measures the deselected gap before the driver turns on. The bench's memory model returns a poison byte until the read phase has lasted the required cycles, so a shortened read shows up as wrong data. A request offered and withdrawn while the controller is busy is followed by a read-back, which shows that no write took place.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_TURN  = 2'd3
  } ctlState_t;

  // Strobes from control to datapath, computed for the next cycle.
  typedef struct packed {
    logic loadReq;
    logic selActive;
    logic readOe;
    logic writeEn;
    logic capture;
    logic donePulse;
  } ctlStrobes_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramCtlFsm.sv
module sramCtlFsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC   = 7,
  parameter int WR_CYC   = 7,
  parameter int TURN_CYC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctlStrobes_t strobes
);

  localparam int MAX_CYC = maxOf2(maxOf2(RD_CYC, WR_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctlState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             cntDone;

  assign cntDone  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          nextState = reqWrite ? ST_WRITE : ST_READ;
          nextCnt   = reqWrite ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ: begin
        if (cntDone) begin
          nextState = ST_TURN;
          nextCnt   = CNT_W'(TURN_CYC - 1);
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_WRITE: begin
        if (cntDone) nextState = ST_IDLE;
        else         nextCnt   = cnt - 1'b1;
      end
      ST_TURN: begin
        if (cntDone) nextState = ST_IDLE;
        else         nextCnt   = cnt - 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.loadReq   = (state == ST_IDLE) && reqValid;
    strobes.selActive = (nextState == ST_READ) || (nextState == ST_WRITE);
    strobes.readOe    = (nextState == ST_READ);
    strobes.writeEn   = (nextState == ST_WRITE);
    strobes.capture   = (state == ST_READ) && cntDone;
    strobes.donePulse = (state == ST_WRITE) && cntDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  // R3
  idle_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (cnt == '0));

  // R8
  read_then_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && cntDone) |=> (state == ST_TURN));

endmodule

// File: rtl/sramCtlDatapath.sv
module sramCtlDatapath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqDriveEn,
  output logic              memCeLowN,
  output logic              memCeHigh,
  output logic              memOeN,
  output logic              memRwN,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspValid,
  output logic              wrDone
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
    end else if (strobes.loadReq) begin
      memAddr  <= reqAddr;
      memDqOut <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeLowN    <= 1'b1;
      memCeHigh    <= 1'b0;
      memOeN       <= 1'b1;
      memRwN       <= 1'b1;
      memDqDriveEn <= 1'b0;
    end else begin
      memCeLowN    <= ~strobes.selActive;
      memCeHigh    <= strobes.selActive;
      memOeN       <= ~strobes.readOe;
      memRwN       <= ~strobes.writeEn;
      memDqDriveEn <= strobes.writeEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata <= '0;
      rspValid <= 1'b0;
      wrDone   <= 1'b0;
    end else begin
      if (strobes.capture) rspRdata <= memDqIn;
      rspValid <= strobes.capture;
      wrDone   <= strobes.donePulse;
    end
  end

  // R7
  drive_only_writing_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqDriveEn |-> (!memRwN && memOeN));

  // R5
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> !wrDone);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeLowN && $past(!memCeLowN)) |-> $stable(memAddr));

endmodule

// File: rtl/asyncSramCtl.sv
module asyncSramCtl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_ADDR_ACC_NS = 55,
  parameter int T_OE_ACC_NS   = 30,
  parameter int T_RD_CYC_NS   = 55,
  parameter int T_WR_PULSE_NS = 45,
  parameter int T_CE_WR_NS    = 50,
  parameter int T_DSETUP_NS   = 25,
  parameter int T_WR_CYC_NS   = 55,
  parameter int T_RELEASE_NS  = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              wrDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeLowN,
  output logic              memCeHigh,
  output logic              memOeN,
  output logic              memRwN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqDriveEn
);

  localparam int RD_CYC = maxOf2(maxOf2(nsToCycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                        nsToCycles(T_OE_ACC_NS, CLK_PERIOD_NS)),
                                 nsToCycles(T_RD_CYC_NS, CLK_PERIOD_NS));
  localparam int WR_CYC = maxOf2(maxOf2(nsToCycles(T_WR_PULSE_NS, CLK_PERIOD_NS),
                                        nsToCycles(T_CE_WR_NS, CLK_PERIOD_NS)),
                                 maxOf2(nsToCycles(T_DSETUP_NS, CLK_PERIOD_NS),
                                        nsToCycles(T_WR_CYC_NS, CLK_PERIOD_NS)));
  localparam int TURN_CYC = nsToCycles(T_RELEASE_NS, CLK_PERIOD_NS);

  ctlStrobes_t strobes;

  sramCtlFsm #(
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .TURN_CYC(TURN_CYC)
  ) fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobes (strobes)
  );

  sramCtlDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .memDqIn     (memDqIn),
    .memAddr     (memAddr),
    .memDqOut    (memDqOut),
    .memDqDriveEn(memDqDriveEn),
    .memCeLowN   (memCeLowN),
    .memCeHigh   (memCeHigh),
    .memOeN      (memOeN),
    .memRwN      (memRwN),
    .rspRdata    (rspRdata),
    .rspValid    (rspValid),
    .wrDone      (wrDone)
  );

  // R2
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeLowN && !memCeHigh && memOeN && !memDqDriveEn));

  // R3
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(memAddr));

endmodule

// File: tb/asyncSramCtl_tb.sv
module asyncSramCtl_tb_top;

  localparam int PERIOD = 8;

  function automatic int ceilCyc(input int ns);
    int c;
    c = (ns + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_EXP   = mx(mx(ceilCyc(55), ceilCyc(30)), ceilCyc(55));
  localparam int WR_EXP   = mx(mx(ceilCyc(45), ceilCyc(50)), mx(ceilCyc(25), ceilCyc(55)));
  localparam int TURN_EXP = ceilCyc(25);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid, wrDone;
  logic [7:0]  rspRdata;
  logic [18:0] memAddr;
  logic        memCeLowN, memCeHigh, memOeN, memRwN, memDqDriveEn;
  logic [7:0]  memDqOut, memDqIn;

  always #(PERIOD / 2) clk = ~clk;

  asyncSramCtl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .wrDone(wrDone),
    .memAddr(memAddr), .memCeLowN(memCeLowN), .memCeHigh(memCeHigh),
    .memOeN(memOeN), .memRwN(memRwN), .memDqOut(memDqOut),
    .memDqIn(memDqIn), .memDqDriveEn(memDqDriveEn)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model and reference contents
  logic [7:0] modelMem [int];
  logic [7:0] refMem [int];
  int rdRun = 0, wrRun = 0, gapRun = 1000, writesSeen = 0;
  int wrAddrQ = 0;
  logic [7:0] wrDataQ = '0;

  function automatic logic [7:0] initByte(input int a);
    return 8'((a * 37) ^ (a >> 8));
  endfunction
  function automatic logic [7:0] modelRead(input int a);
    return modelMem.exists(a) ? modelMem[a] : initByte(a);
  endfunction
  function automatic logic [7:0] refRead(input int a);
    return refMem.exists(a) ? refMem[a] : initByte(a);
  endfunction

  always @* memDqIn = (rdRun >= RD_EXP) ? modelRead(int'(memAddr)) : 8'hEE;

  always @(negedge clk) begin
    if (rstN) begin
      automatic bit sel = !memCeLowN && memCeHigh;
      if (memDqDriveEn && !memOeN) check(0, "R7 contention", 1, 0);
      if (sel && memRwN && !memOeN) begin
        rdRun++;
        gapRun = 0;
      end else begin
        if (rdRun > 0) check(rdRun == RD_EXP, "R4 read length", rdRun, RD_EXP);
        rdRun = 0;
        if (!(sel && !memRwN)) gapRun++;
      end
      if (sel && !memRwN) begin
        if (wrRun == 0) check(gapRun >= TURN_EXP, "R8 turnaround", gapRun, TURN_EXP);
        wrRun++;
        if (!memDqDriveEn || !memOeN) check(0, "R6 drive during write", memDqDriveEn, 1);
        wrAddrQ = int'(memAddr);
        wrDataQ = memDqOut;
      end else if (wrRun > 0) begin
        check(wrRun == WR_EXP, "R6 write length", wrRun, WR_EXP);
        check(!memDqDriveEn, "R7 release with rw high", memDqDriveEn, 0);
        modelMem[wrAddrQ] = wrDataQ;
        writesSeen++;
        wrRun = 0;
      end
    end
  end

  task automatic doOp(input bit we, input logic [18:0] a, input logic [7:0] d);
    int k;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    check(memCeLowN && !memCeHigh && memOeN && !memDqDriveEn, "R2 standby", memCeLowN, 1);
    reqValid = 1'b1; reqWrite = we; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    k = 1;
    check(!reqReady, "R3 busy after accept", reqReady, 0);
    while (!(we ? wrDone : rspValid) && k < 100) begin
      @(negedge clk);
      k++;
    end
    if (we) begin
      check(k == WR_EXP + 1, "R9 done latency", k, WR_EXP + 1);
      refMem[int'(a)] = d;
      @(negedge clk);
      check(!wrDone, "R9 done one cycle", wrDone, 0);
    end else begin
      check(k == RD_EXP + 1, "R5 rsp latency", k, RD_EXP + 1);
      check(rspRdata == refRead(int'(a)), "R5 read data", rspRdata, refRead(int'(a)));
      k = 0;
      @(negedge clk);
      check(!rspValid, "R5 rsp one cycle", rspValid, 0);
      check(rspRdata == refRead(int'(a)), "R5 data held", rspRdata, refRead(int'(a)));
      while (!reqReady && k < 100) begin
        @(negedge clk);
        k++;
      end
      check(k == TURN_EXP - 1, "R8 ready after turnaround", k + 1, TURN_EXP);
    end
  endtask

  initial begin
    automatic int seedDummy = $urandom(32'd20240611);
    automatic int savedWrites;
    repeat (3) @(negedge clk);
    check(reqReady && memCeLowN && !memCeHigh && memOeN && memRwN && !memDqDriveEn
          && !rspValid && !wrDone, "R1 reset state", {reqReady, memCeLowN, memCeHigh}, 3'b110);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && memCeLowN && !memCeHigh, "R1 after release", reqReady, 1);

    // Directed corners: lowest and highest address, untouched address
    doOp(1'b1, 19'h00000, 8'h5A);
    doOp(1'b1, 19'h7FFFF, 8'hA5);
    doOp(1'b0, 19'h00000, 8'h00);
    doOp(1'b0, 19'h7FFFF, 8'h00);
    doOp(1'b0, 19'h12345, 8'h00);
    // Read immediately followed by write to the same word (R8 gap)
    doOp(1'b0, 19'h00400, 8'h00);
    doOp(1'b1, 19'h00400, 8'hC3);
    doOp(1'b0, 19'h00400, 8'h00);

    // R3: request offered only while busy is ignored
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 19'h00400;
    @(negedge clk);
    reqValid = 1'b0;
    savedWrites = writesSeen;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 19'h00400; reqWdata = 8'hFF;
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
    repeat (WR_EXP + 3) @(negedge clk);
    check(writesSeen == savedWrites, "R3 busy request ignored", writesSeen, savedWrites);
    doOp(1'b0, 19'h00400, 8'h00);

    // Constrained random traffic over a small address pool
    for (int i = 0; i < 300; i++) begin
      automatic logic [18:0] a = 19'((($urandom % 24) * 21841) & 19'h7FFFF);
      automatic bit we = ($urandom % 2) == 1;
      doOp(we, a, 8'($urandom));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule